// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one data word into an asynchronous serial frame on a single TX line. A word is offered with a valid/ready handshake together with an address-marker flag and an 8-bit format byte. The format byte picks the number of data bits (1 to 8), the number of stop bits, whether a parity bit is sent and its sense, and whether an extra address bit rides in each frame. An outside baud-tick enable paces the line, and every serial bit lasts sixteen of those ticks.

The format byte and the word are captured together on the cycle the handshake completes. From then on the frame is fixed: the source may change the word or the format at any time without disturbing the frame in flight. A format enable bit must be set for the block to work at all. While it is clear the transmitter refuses words and keeps the line at its idle level.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in flight, `tx_line` is 1 and `tx_busy` is 0. `tx_ready` is 1 in that state when `tx_cfg[4]` is 1.
- R2: A frame is sent in this order: a start bit of 0, the data bits with the least significant bit first, the address bit if enabled, the parity bit if enabled, then the stop bits of 1.
- R3: The number of data bits is `tx_cfg[2:0]` plus one: 0 gives 1 bit and 7 gives 8 bits. Data bits above that count are not sent.
- R4: With `tx_cfg[7]` at 0 the frame ends with one stop bit. With 1 it ends with two.
- R5: With `tx_cfg[5]` at 1 a parity bit is sent. It is computed over the data bits sent plus the address bit when present. `tx_cfg[6]` at 0 makes the total number of ones even, and at 1 makes it odd. With `tx_cfg[5]` at 0 no parity bit is sent.
- R6: With `tx_cfg[3]` at 1 one address bit equal to `tx_addr_flag` follows the data bits. With 0 no address bit is sent.
- R7: With `tx_cfg[4]` at 0 no frame is started: `tx_ready` is 0, `tx_busy` stays 0 and `tx_line` stays 1, even with `tx_valid` high.
- R8: Every bit of a frame, the start bit included, lasts exactly 16 cycles in which `baud_tick` is 1. `tx_line` changes only on a cycle with `baud_tick` high. A tick on the accepting cycle is not counted.
- R9: The format byte, data word and address flag are captured when a word is accepted. Later changes to those inputs do not affect the frame in flight.
- R10: A word is accepted only on a cycle with `tx_valid` and `tx_ready` both high. From the next cycle `tx_busy` is 1 and `tx_ready` is 0 until the last stop bit has ended. On the cycle after that, `tx_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Baud enable; 16 ticks form one bit time |
| tx_cfg | input | 8 | Format byte: [2:0] length-1, [3] address mode, [4] enable, [5] parity on, [6] odd parity, [7] two stops |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Word may be accepted this cycle |
| tx_data | input | 8 | Data word, LSB sent first |
| tx_addr_flag | input | 1 | Value of the address bit in address mode |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in flight |

## Verification
The start bit appears on `tx_line` on the clock edge that accepts the word. Each later bit boundary falls on the edge that carries the sixteenth counted tick of the current bit, and `tx_ready` comes back on the edge where the last stop bit ends. The bench counts the ticks it drives itself. It samples the line on the falling edge after the eighth tick of each bit, and again after the fifteenth, to show that the bit has not yet moved. It checks ready and busy on the falling edge right after the closing tick. With random tick densities, the bit windows never line up with a fixed cycle count, so every check waits on counted ticks and never on elapsed cycles.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned OVERSAMPLE = 16;
  // start + data + address + parity + two stops
  localparam int unsigned FRAME_W    = 1 + DATA_W + 1 + 1 + 2;
  localparam int unsigned LEN_W      = $clog2(FRAME_W + 1);

  // Field order matches the bit positions of the format byte, msb first.
  typedef struct packed {
    logic       two_stop;  // [7]
    logic       par_odd;   // [6]
    logic       par_en;    // [5]
    logic       run_en;    // [4]
    logic       addr_en;   // [3]
    logic [2:0] len_m1;    // [2:0]
  } fmt_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

endpackage

// File: rtl/uart_tx_rstsync.sv
module uart_tx_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int unsigned CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign bit_end = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (run && tick)   cnt_d = bit_end ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_frame_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  logic               addr_flag,
  input  fmt_t               fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  localparam int unsigned SELW = $clog2(DATA_W);

  logic [LEN_W-1:0] pos;
  logic             par;

  always_comb begin
    frame    = '1;          // unused tail positions read as stop level
    frame[0] = 1'b0;        // start bit
    pos      = LEN_W'(1);
    par      = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (SELW'(i) <= fmt.len_m1) begin
        frame[pos] = data[i];
        par        = par ^ data[i];
        pos        = pos + LEN_W'(1);
      end
    end
    if (fmt.addr_en) begin
      frame[pos] = addr_flag;
      par        = par ^ addr_flag;
      pos        = pos + LEN_W'(1);
    end
    if (fmt.par_en) begin
      frame[pos] = par ^ fmt.par_odd;
      pos        = pos + LEN_W'(1);
    end
    len = pos + (fmt.two_stop ? LEN_W'(2) : LEN_W'(1));
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [7:0]        tx_cfg,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr_flag,
  output logic              tx_line,
  output logic              tx_busy
);
  fmt_t               fmt_in;
  logic               rst_ok;
  logic               accept;
  logic               bit_end;
  logic [FRAME_W-1:0] frame_new;
  logic [LEN_W-1:0]   len_new;

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [LEN_W-1:0]   idx_q, idx_d;
  logic               line_q, line_d;

  assign fmt_in = fmt_t'(tx_cfg);

  uart_tx_rstsync #(.STAGES(2)) u_rstsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  uart_tx_framer u_framer (
    .data      (tx_data),
    .addr_flag (tx_addr_flag),
    .fmt       (fmt_in),
    .frame     (frame_new),
    .len       (len_new)
  );

  uart_tx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .run     (state_q == ST_SEND),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  assign tx_ready = rst_ok && (state_q == ST_IDLE) && fmt_in.run_en;
  assign accept   = tx_valid && tx_ready;
  assign tx_busy  = (state_q == ST_SEND);
  assign tx_line  = line_q;

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    len_d   = len_q;
    idx_d   = idx_q;
    line_d  = line_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SEND;
          frame_d = frame_new;
          len_d   = len_new;
          idx_d   = '0;
          line_d  = frame_new[0];
        end
      end
      ST_SEND: begin
        if (bit_end) begin
          if (idx_q == len_q - LEN_W'(1)) begin
            state_d = ST_IDLE;
            line_d  = 1'b1;
          end else begin
            idx_d  = idx_q + LEN_W'(1);
            line_d = frame_q[idx_q + LEN_W'(1)];
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      line_q  <= line_d;
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic [7:0] tx_cfg,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_line,
  input logic       tx_busy
);
  // R1: line at idle level whenever no frame is in flight
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  // R2: the first bit of every frame is a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_line);

  // R7: disabled format byte never opens a frame
  p_off_no_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_cfg[4] && !tx_busy) |=> !tx_busy);

  // R8: nothing moves on a cycle without a tick
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !baud_tick) |=> ($stable(tx_line) && tx_busy));

  // R10: handshake opens a frame and closes ready
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_busy && !tx_ready));

  // R10: ready and busy never together
  p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !tx_busy);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .tx_cfg    (tx_cfg),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_line   (tx_line),
  .tx_busy   (tx_busy)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic [7:0] tx_cfg;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] tx_data;
  logic       tx_addr_flag;
  logic       tx_line;
  logic       tx_busy;

  int compared   = 0;
  int mismatched = 0;
  int tick_rate  = 100;

  uart_frame_tx u_uart_frame_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_tick    (baud_tick),
    .tx_cfg       (tx_cfg),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_addr_flag (tx_addr_flag),
    .tx_line      (tx_line),
    .tx_busy      (tx_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk)
    baud_tick <= (($urandom % 100) < tick_rate);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int n_data(input logic [7:0] c);
    return int'(c[2:0]) + 1;
  endfunction

  function automatic int exp_len(input logic [7:0] c);
    return 1 + n_data(c) + int'(c[3]) + int'(c[5]) + 1 + int'(c[7]);
  endfunction

  function automatic logic [15:0] exp_frame(input logic [7:0] d,
                                            input logic a, input logic [7:0] c);
    logic [15:0] f;
    int p;
    logic par;
    f = '1; f[0] = 1'b0; p = 1; par = 1'b0;
    for (int i = 0; i < n_data(c); i++) begin
      f[p] = d[i]; par ^= d[i]; p++;
    end
    if (c[3]) begin f[p] = a; par ^= a; p++; end
    if (c[5]) begin f[p] = par ^ c[6]; p++; end
    return f;
  endfunction

  function automatic string tag_of(input int b, input logic [7:0] c, input bit scr);
    int nd;
    nd = n_data(c);
    if (scr) return "R9";
    if (b == 0) return "R2";
    if (b <= nd) return "R3";
    if (c[3] && b == nd + 1) return "R6";
    if (c[5] && b == nd + 1 + int'(c[3])) return "R5";
    return "R4";
  endfunction

  task automatic wait_ticks(input int n);
    int c;
    c = 0;
    while (c < n) begin
      @(posedge clk);
      if (baud_tick) c++;
    end
  endtask

  task automatic send_check(input logic [7:0] d, input logic a,
                            input logic [7:0] c, input bit scr);
    logic [15:0] f;
    int n;
    f = exp_frame(d, a, c);
    n = exp_len(c);
    @(negedge clk);
    tx_cfg = c; tx_data = d; tx_addr_flag = a;
    chk(tx_ready === 1'b1, "R10", "ready before offer", {31'd0, tx_ready}, 32'd1);
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    if (scr) begin
      tx_cfg = 8'($urandom) | 8'h10;
      tx_data = 8'($urandom);
      tx_addr_flag = ~a;
    end
    for (int b = 0; b < n; b++) begin
      wait_ticks(8);
      @(negedge clk);
      chk(tx_line === f[b], tag_of(b, c, scr), $sformatf("bit %0d mid", b),
          {31'd0, tx_line}, {31'd0, f[b]});
      chk(tx_busy === 1'b1 && tx_ready === 1'b0, "R10", "busy during frame",
          {30'd0, tx_busy, tx_ready}, 32'h2);
      wait_ticks(7);
      @(negedge clk);
      chk(tx_line === f[b], "R8", $sformatf("bit %0d after 15 ticks", b),
          {31'd0, tx_line}, {31'd0, f[b]});
      wait_ticks(1);
    end
    @(negedge clk);
    tx_cfg = tx_cfg | 8'h10;
    #1;
    chk(tx_busy === 1'b0 && tx_ready === 1'b1 && tx_line === 1'b1, "R10",
        "idle after last stop", {29'd0, tx_busy, tx_ready, tx_line}, 32'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tx_cfg = 8'h10; tx_valid = 1'b0; tx_data = '0; tx_addr_flag = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_line === 1'b1 && tx_busy === 1'b0 && tx_ready === 1'b1, "R1",
        "reset state", {29'd0, tx_line, tx_busy, tx_ready}, 32'h5);

    // R3 minimum length, defaults
    tick_rate = 100;
    send_check(8'hFE, 1'b0, 8'h10, 1'b0);
    // R3 full length, R6 address, R5 odd parity, R4 two stops
    send_check(8'hA5, 1'b1, 8'hFF, 1'b0);
    // R5 even parity with address flag 0
    send_check(8'h3C, 1'b0, 8'h3D, 1'b0);
    // R6 address bit of 1, no parity
    tick_rate = 40;
    send_check(8'h01, 1'b1, 8'h1A, 1'b0);
    // R9 format changes mid frame
    send_check(8'h96, 1'b1, 8'hB7, 1'b1);

    // R7 disabled: no frame despite valid
    @(negedge clk);
    tx_cfg = 8'hEF; tx_valid = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk(tx_ready === 1'b0 && tx_busy === 1'b0 && tx_line === 1'b1, "R7",
          "disabled holds idle", {29'd0, tx_ready, tx_busy, tx_line}, 32'h1);
    end
    tx_valid = 1'b0; tx_cfg = 8'h10;

    for (int k = 0; k < 36; k++) begin
      case ($urandom % 3)
        0: tick_rate = 100;
        1: tick_rate = 50;
        default: tick_rate = 30;
      endcase
      send_check(8'($urandom), 1'($urandom), 8'($urandom) | 8'h10, bit'(k % 2));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule